// File: doc/BRIEF.md
# Shared Cache Maintenance Sequencer

This controller sits next to a small write-back cache that two hardware threads share. It carries out three maintenance commands on that cache: a full flush that writes modified lines to memory and then drops them, a full discard that drops every line without writing anything back, and a flush of the one line that holds a given address. Either thread may issue a command, and the command always acts on the shared cache as a whole. The sequencer has no notion of which thread filled a line.

The tag/state array lives outside the block. The sequencer places a set and way index on the array port and reads the valid, dirty and tag fields back in the same cycle. It clears an entry with a one-cycle strobe. Write-backs leave on a request/acknowledge memory port. Every command except the reserved opcode ends with a notification cycle on a broadcast bus port, and then a one-cycle completion pulse that carries the issuing thread's id. While a full command runs, both threads are stalled.

The controller is a five-state machine:
- `S_IDLE` waits for a command. On an accepted opcode 11 it goes to `S_DONE`; on any other accepted opcode it goes to `S_SCAN`.
- `S_SCAN` examines one entry per cycle. It goes to `S_WB` when the entry needs a write-back, to `S_BUS` when the walk is over, and otherwise stays and advances to the next entry.
- `S_WB` holds the memory request. On acknowledge it returns to `S_SCAN`, or goes to `S_BUS` when nothing is left to examine.
- `S_BUS` holds the broadcast request until it is acknowledged, then goes to `S_DONE`.
- `S_DONE` lasts one cycle and returns to `S_IDLE`.

Top module: `cache_maint_seq`

## Requirements
- R1: `cmd_ready` is high only in `S_IDLE`, and a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. Opcodes are 00 full write-back-and-invalidate, 01 full discard, 10 line flush and 11 reserved. No command is accepted until the current one has finished.
- R2: A full write-back-and-invalidate issues one memory write-back for every entry that is both valid and dirty. The write-back address is {tag, set, zero offset}. An entry is cleared only in the cycle its write-back is acknowledged. Afterwards every entry is invalid.
- R3: Full commands walk the entries in ascending set order, with way 0 before way 1 in each set, so write-backs leave in that order.
- R4: A full discard clears every entry and raises no memory request, so dirty data is lost.
- R5: During a full command both bits of `stall` are high, from the cycle after acceptance up to the cycle before the done pulse. At all other times both bits are low, including for the whole of a line flush.
- R6: A full command ends with one broadcast request with `bus_kind` equal to its opcode and `bus_addr` equal to 0. The request stays high with stable fields until `bus_ack`.
- R7: A line flush that hits a valid dirty entry writes that line back to {tag, set, zero offset}, clears only that entry, then broadcasts with `bus_kind` 10 and the line-aligned address.
- R8: A line flush that hits a valid clean entry clears it without a write-back, then broadcasts.
- R9: A line flush that misses, including a tag match on an invalid entry, changes no entry and writes nothing back, but still broadcasts.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack`.
- R11: `done` is a one-cycle pulse in the cycle after the `bus_ack` cycle, and `done_tid` equals the issuing thread's `cmd_tid`.
- R12: The outcome of a command does not depend on `cmd_tid`. Entries carry no owner, so either thread's command acts on any line.
- R13: Opcode 11 is accepted, touches neither the array, memory nor the bus, leaves `stall` low, and raises `done` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 2 | Command opcode |
| cmd_addr | input | ADDR_W | Byte address used by the line flush |
| cmd_tid | input | 1 | Issuing thread id |
| stall | output | 2 | Stall, one bit for each thread |
| arr_set | output | SET_W | Array set index |
| arr_way | output | WAY_W | Array way index |
| arr_rd_valid | input | 1 | Valid bit of the indexed entry |
| arr_rd_dirty | input | 1 | Dirty bit of the indexed entry |
| arr_rd_tag | input | TAG_W | Tag of the indexed entry |
| arr_clr_en | output | 1 | Clear valid and dirty bits of the indexed entry |
| mem_req | output | 1 | Write-back request |
| mem_addr | output | ADDR_W | Line address being written back |
| mem_ack | input | 1 | Write-back accepted |
| bus_req | output | 1 | Broadcast notification request |
| bus_kind | output | 2 | Opcode of the finishing command |
| bus_addr | output | ADDR_W | Line-aligned address, or 0 for full commands |
| bus_ack | input | 1 | Broadcast accepted |
| done | output | 1 | Completion pulse |
| done_tid | output | 1 | Thread id of the completed command |

## Verification
The hardest case to reach from the ports is a memory acknowledge that arrives several cycles after the request, in the middle of a full walk. In that case the entry must stay valid and dirty, with the same address on the port, until the exact acknowledge cycle, and only then may the walk move on. The bench's memory responder varies its latency from one write-back to the next. It is loaded with a fill pattern that mixes dirty, clean and invalid entries in both ways, so waits fall on neighbouring entries and in both ways of the same set. A line flush aimed at a tag that sits in an invalid way covers the miss case that looks like a hit.

// File: rtl/cms_pkg.sv
package cms_pkg;

    typedef enum logic [1:0] {
        OP_WBINV = 2'b00,
        OP_INV   = 2'b01,
        OP_LINE  = 2'b10,
        OP_NOP   = 2'b11
    } cms_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_WB,
        S_BUS,
        S_DONE
    } cms_state_e;

endpackage

// File: rtl/cms_cmd_reg.sv
module cms_cmd_reg
    import cms_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              tid_in,
    output cms_op_e           op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              tid_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NOP;
            addr_q <= '0;
            tid_q  <= 1'b0;
        end else if (load) begin
            op_q   <= cms_op_e'(op_in);
            addr_q <= addr_in;
            tid_q  <= tid_in;
        end
    end

endmodule

// File: rtl/cms_scan_ctr.sv
module cms_scan_ctr #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             inc,
    output logic [IDX_W-1:0] idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= load_val;
        end else if (inc) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/cms_tag_cmp.sv
module cms_tag_cmp #(
    parameter int TAG_W = 4
) (
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [TAG_W-1:0] want_tag,
    output logic             hit
);

    always_comb begin
        hit = ent_valid && (ent_tag == want_tag);
    end

endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
    import cms_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 4,
    parameter int SETS   = 16,
    parameter int WAYS   = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_tid,
    output logic [1:0]        stall,
    output logic [SET_W-1:0]  arr_set,
    output logic [WAY_W-1:0]  arr_way,
    input  logic              arr_rd_valid,
    input  logic              arr_rd_dirty,
    input  logic [TAG_W-1:0]  arr_rd_tag,
    output logic              arr_clr_en,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic              bus_req,
    output logic [1:0]        bus_kind,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    output logic              done,
    output logic              done_tid
);

    localparam int ENTRIES = SETS * WAYS;
    localparam int IDX_W   = SET_W + WAY_W;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_W) - 1'b1);

    cms_state_e        state_q, state_d;
    cms_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              tid_q;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_start;
    logic              ctr_load, ctr_inc;
    logic              accept;
    logic              is_full;
    logic              hit;
    logic              need_wb;
    logic              last_ent, last_way;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;

    // command capture
    cms_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .op_in   (cmd_op),
        .addr_in (cmd_addr),
        .tid_in  (cmd_tid),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .tid_q   (tid_q)
    );

    // a line flush starts at way 0 of its set, a full command at entry 0
    always_comb begin
        if (cms_op_e'(cmd_op) == OP_LINE) begin
            idx_start = {cmd_addr[OFF_W +: SET_W], WAY_W'(0)};
        end else begin
            idx_start = '0;
        end
    end

    cms_scan_ctr #(.IDX_W(IDX_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (idx_start),
        .inc      (ctr_inc),
        .idx      (idx)
    );

    assign arr_set = idx[IDX_W-1 -: SET_W];
    assign arr_way = idx[WAY_W-1:0];
    assign req_set = addr_q[OFF_W +: SET_W];
    assign req_tag = addr_q[ADDR_W-1 -: TAG_W];

    cms_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
        .ent_valid (arr_rd_valid && (arr_set == req_set)),
        .ent_tag   (arr_rd_tag),
        .want_tag  (req_tag),
        .hit       (hit)
    );

    always_comb begin
        is_full  = (op_q == OP_WBINV) || (op_q == OP_INV);
        last_ent = (idx == IDX_W'(ENTRIES - 1));
        last_way = (arr_way == WAY_W'(WAYS - 1));
        need_wb  = ((op_q == OP_WBINV) && arr_rd_valid && arr_rd_dirty) ||
                   ((op_q == OP_LINE) && hit && arr_rd_dirty);
        accept   = (state_q == S_IDLE) && cmd_valid;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and scan control
    always_comb begin
        state_d  = state_q;
        ctr_load = 1'b0;
        ctr_inc  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    ctr_load = 1'b1;
                    state_d  = (cms_op_e'(cmd_op) == OP_NOP) ? S_DONE : S_SCAN;
                end
            end
            S_SCAN: begin
                if (need_wb) begin
                    state_d = S_WB;
                end else if (is_full) begin
                    if (last_ent) state_d = S_BUS;
                    else          ctr_inc = 1'b1;
                end else if (hit || last_way) begin
                    state_d = S_BUS;
                end else begin
                    ctr_inc = 1'b1;
                end
            end
            S_WB: begin
                if (mem_ack) begin
                    if (is_full && !last_ent) begin
                        ctr_inc = 1'b1;
                        state_d = S_SCAN;
                    end else begin
                        state_d = S_BUS;
                    end
                end
            end
            S_BUS: begin
                if (bus_ack) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready  = (state_q == S_IDLE);
        stall      = (is_full && ((state_q == S_SCAN) || (state_q == S_WB) ||
                                  (state_q == S_BUS))) ? 2'b11 : 2'b00;
        arr_clr_en = ((state_q == S_SCAN) && !need_wb && arr_rd_valid && (is_full || hit)) ||
                     ((state_q == S_WB) && mem_ack);
        mem_req    = (state_q == S_WB);
        mem_addr   = {arr_rd_tag, arr_set, OFF_W'(0)};
        bus_req    = (state_q == S_BUS);
        bus_kind   = op_q;
        bus_addr   = (op_q == OP_LINE) ? (addr_q & LINE_MASK) : '0;
        done       = (state_q == S_DONE);
        done_tid   = tid_q;
    end

endmodule

// File: rtl/cms_seq_chk.sv
module cms_seq_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic [1:0]        stall,
    input logic              arr_rd_valid,
    input logic              arr_rd_dirty,
    input logic              arr_clr_en,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              bus_req,
    input logic [1:0]        bus_kind,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              done,
    input logic [1:0]        op_q
);

    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || bus_req || (stall != 2'b00)) |-> !cmd_ready);

    assert_dirty_clear_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_clr_en && arr_rd_valid && arr_rd_dirty && (op_q != 2'b01)) |-> mem_ack);

    assert_discard_no_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_q == 2'b01) && !cmd_ready) |-> !mem_req);

    assert_stall_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall[0] == stall[1]);

    assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_kind) && $stable(bus_addr)));

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q != 2'b11)) |-> $past(bus_ack));

endmodule

bind cache_maint_seq cms_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_ready    (cmd_ready),
    .stall        (stall),
    .arr_rd_valid (arr_rd_valid),
    .arr_rd_dirty (arr_rd_dirty),
    .arr_clr_en   (arr_clr_en),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .bus_req      (bus_req),
    .bus_kind     (bus_kind),
    .bus_addr     (bus_addr),
    .bus_ack      (bus_ack),
    .done         (done),
    .op_q         (op_q)
);

// File: tb/tb_cache_maint_seq.sv
`timescale 1ns/1ps
module tb_cache_maint_seq;

    localparam int ADDR_W = 12;
    localparam int OFF_W  = 4;
    localparam int SETS   = 16;
    localparam int WAYS   = 2;
    localparam int SET_W  = 4;
    localparam int WAY_W  = 1;
    localparam int TAG_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [1:0]        cmd_op = 2'b11;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              cmd_tid = 1'b0;
    logic [1:0]        stall;
    logic [SET_W-1:0]  arr_set;
    logic [WAY_W-1:0]  arr_way;
    logic              arr_rd_valid, arr_rd_dirty;
    logic [TAG_W-1:0]  arr_rd_tag;
    logic              arr_clr_en;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic              bus_req;
    logic [1:0]        bus_kind;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_ack = 1'b0;
    logic              done, done_tid;

    cache_maint_seq dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_tid(cmd_tid), .stall(stall),
        .arr_set(arr_set), .arr_way(arr_way), .arr_rd_valid(arr_rd_valid),
        .arr_rd_dirty(arr_rd_dirty), .arr_rd_tag(arr_rd_tag), .arr_clr_en(arr_clr_en),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .bus_req(bus_req), .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_ack(bus_ack),
        .done(done), .done_tid(done_tid)
    );

    // array model: the bench owns the tag/state storage
    logic             m_v [SETS][WAYS];
    logic             m_d [SETS][WAYS];
    logic [TAG_W-1:0] m_t [SETS][WAYS];
    logic             e_v [SETS][WAYS];

    assign arr_rd_valid = m_v[arr_set][arr_way];
    assign arr_rd_dirty = m_d[arr_set][arr_way];
    assign arr_rd_tag   = m_t[arr_set][arr_way];

    always @(posedge clk) begin
        if (arr_clr_en) begin
            m_v[arr_set][arr_way] <= 1'b0;
            m_d[arr_set][arr_way] <= 1'b0;
        end
    end

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard queues
    logic [ADDR_W-1:0] exp_wb[$];
    logic [1:0]        exp_bkind[$];
    logic [ADDR_W-1:0] exp_baddr[$];
    logic              exp_dtid[$];
    logic              exp_dbus[$];

    bit    full_win = 0;
    bit    done_seen = 0;
    int    done_cnt = 0;
    int    stall_bad = 0;
    int    stall_bad_val = 0;
    int    mem_wait = 0;
    int    wb_seen = 0;
    string wb_tag = "R2 R3";
    // monitor-side mismatches are recorded and reported by the driver
    int    mon_bad = 0;
    int    mon_act = 0;
    int    mon_exp = 0;
    string mon_tag = "";

    // monitor and responders, all at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) full_win = 0;
            if (stall !== (full_win ? 2'b11 : 2'b00)) begin
                stall_bad++;
                stall_bad_val = int'(stall);
            end
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (mem_wait > 0) begin
                    mem_wait--;
                end else begin
                    if (exp_wb.size() == 0) begin
                        mon_bad++; mon_tag = wb_tag; mon_act = int'(mem_addr); mon_exp = -1;
                    end else begin
                        logic [ADDR_W-1:0] ea;
                        ea = exp_wb.pop_front();
                        if (mem_addr !== ea) begin
                            mon_bad++; mon_tag = wb_tag; mon_act = int'(mem_addr); mon_exp = int'(ea);
                        end
                    end
                    mem_ack = 1'b1;
                    wb_seen++;
                    mem_wait = wb_seen % 4;
                end
            end
            if (done) begin
                done_cnt++;
                if (exp_dtid.size() == 0) begin
                    mon_bad++; mon_tag = "R11 unexpected done"; mon_act = 1; mon_exp = 0;
                end else begin
                    logic et, eb;
                    et = exp_dtid.pop_front();
                    eb = exp_dbus.pop_front();
                    if (done_tid !== et) begin
                        mon_bad++; mon_tag = "R11 done_tid"; mon_act = int'(done_tid); mon_exp = int'(et);
                    end
                    if (eb && !bus_ack) begin
                        mon_bad++; mon_tag = "R11 done not after bus_ack"; mon_act = 0; mon_exp = 1;
                    end
                end
                done_seen = 1;
            end
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (exp_bkind.size() == 0) begin
                    mon_bad++; mon_tag = "R13 unexpected bus cycle"; mon_act = int'(bus_kind); mon_exp = -1;
                end else begin
                    logic [1:0]        ek;
                    logic [ADDR_W-1:0] eadr;
                    ek = exp_bkind.pop_front();
                    eadr = exp_baddr.pop_front();
                    if (bus_kind !== ek || bus_addr !== eadr) begin
                        mon_bad++; mon_tag = "R6 R7 bus fields";
                        mon_act = int'({bus_kind, bus_addr}); mon_exp = int'({ek, eadr});
                    end
                end
                bus_ack = 1'b1;
            end
        end
    end

    task automatic set_line(input int s, input int w, input bit v, input bit d, input int t);
        m_v[s][w] <= v;
        m_d[s][w] <= d;
        m_t[s][w] <= TAG_W'(t);
    endtask

    task automatic fill_pattern();
        @(negedge clk);
        for (int s = 0; s < SETS; s++) begin
            set_line(s, 0, 1'b1, (s % 3) == 0, s ^ 5);
            set_line(s, 1, (s % 2) == 1, (s % 4) == 1, s + 1);
        end
        @(negedge clk);
    endtask

    // driver: builds expectations, issues the command, waits for completion
    task automatic run_cmd(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                           input logic tid, input string tag);
        bit ready_at;
        int sb0, mb0, mism, guard;
        int s_req;
        logic [TAG_W-1:0] t_req;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) e_v[s][w] = m_v[s][w];
        s_req = int'(addr[OFF_W +: SET_W]);
        t_req = addr[ADDR_W-1 -: TAG_W];
        if (op == 2'b00 || op == 2'b01) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    if (op == 2'b00 && m_v[s][w] && m_d[s][w])
                        exp_wb.push_back({m_t[s][w], SET_W'(s), OFF_W'(0)});
                    e_v[s][w] = 1'b0;
                end
            exp_bkind.push_back(op);
            exp_baddr.push_back('0);
        end else if (op == 2'b10) begin
            for (int w = 0; w < WAYS; w++) begin
                if (m_v[s_req][w] && m_t[s_req][w] == t_req) begin
                    if (m_d[s_req][w]) exp_wb.push_back({t_req, SET_W'(s_req), OFF_W'(0)});
                    e_v[s_req][w] = 1'b0;
                end
            end
            exp_bkind.push_back(op);
            exp_baddr.push_back({addr[ADDR_W-1:OFF_W], OFF_W'(0)});
        end
        exp_dtid.push_back(tid);
        exp_dbus.push_back(op != 2'b11);
        wb_tag = tag;
        sb0 = stall_bad;
        mb0 = mon_bad;
        done_seen = 0;
        done_cnt = 0;

        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_tid = tid;
        ready_at = cmd_ready;
        @(posedge clk);
        full_win = (op == 2'b00 || op == 2'b01);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(ready_at, {"R1 ready when idle ", tag}, int'(ready_at), 1);
        check(!cmd_ready, {"R1 busy not ready ", tag}, int'(cmd_ready), 0);
        guard = 0;
        while (!done_seen && guard < 3000) begin
            @(posedge clk);
            guard++;
        end
        check(done_seen, {"R11 done reached ", tag}, int'(done_seen), 1);
        repeat (3) @(negedge clk);
        check(done_cnt == 1, {"R11 single done pulse ", tag}, done_cnt, 1);
        check(mon_bad == mb0, mon_tag, mon_act, mon_exp);
        check(stall_bad == sb0, {"R5 stall ", tag}, stall_bad_val, full_win ? 3 : 0);
        check(exp_wb.size() == 0, {"R2 R7 missing write-back ", tag}, exp_wb.size(), 0);
        check(exp_bkind.size() == 0, {"R6 R9 missing bus cycle ", tag}, exp_bkind.size(), 0);
        mism = 0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (m_v[s][w] !== e_v[s][w]) mism++;
        check(mism == 0, {"array state ", tag}, mism, 0);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_v[s][w] = 1'b0; m_d[s][w] = 1'b0; m_t[s][w] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R1 and R5
        check(cmd_ready === 1'b1, "R1 reset ready", int'(cmd_ready), 1);
        check(stall === 2'b00, "R5 reset stall", int'(stall), 0);
        check(!mem_req && !bus_req && !done, "R6 R10 reset idle outputs",
              int'({mem_req, bus_req, done}), 0);

        // R2 R3 R10 R12: full flush issued by thread 1, mixed pattern, varied ack latency
        fill_pattern();
        run_cmd(2'b00, 12'h000, 1'b1, "R2 R3 R10 R12 wbinv");
        // R4: discard loses dirty data, no write-backs
        fill_pattern();
        run_cmd(2'b01, 12'h000, 1'b0, "R4 discard");
        // R7: dirty hit in way 1 of set 5 (tag 6), unaligned address, thread 0
        fill_pattern();
        run_cmd(2'b10, {4'd6, 4'd5, 4'hA}, 1'b0, "R7 R12 line dirty");
        // R8: clean hit in way 0 of set 4 (tag 1)
        run_cmd(2'b10, {4'd1, 4'd4, 4'h3}, 1'b1, "R8 line clean");
        // R9: miss on set 7
        run_cmd(2'b10, {4'd15, 4'd7, 4'h0}, 1'b0, "R9 line miss");
        // R9: tag 7 present in an invalid way of set 6
        run_cmd(2'b10, {4'd7, 4'd6, 4'h8}, 1'b1, "R9 invalid tag match");
        // R13: reserved opcode
        run_cmd(2'b11, 12'hABC, 1'b1, "R13 reserved");
        // R6: full flush of a cache with nothing dirty
        run_cmd(2'b01, 12'h000, 1'b1, "R6 discard");
        run_cmd(2'b00, 12'h000, 1'b0, "R6 wbinv empty");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule